// File: doc/BRIEF.md
# Position-Dependent RESET Pulse Timer

This block sits inside a resistive-memory controller and decides how long each RESET write pulse is driven. The subarray is split into 64 blocks. A block's RESET latency depends on its distance from the write drivers, and blocks at the same distance behave alike. The timer therefore keeps a 16-entry table of 16-bit latencies, counted in controller clock cycles. It folds each 6-bit block ID onto one table entry, so that every entry covers two neighbouring blocks at one end of the array and their mirror pair at the other end.

A RESET request may name one or two blocks that are reset together. When the request is accepted, the timer looks up both latencies and loads a down-counter with the larger one. It then holds the RESET drive enable high for exactly that many cycles and ends the pulse as soon as that time has passed, without waiting for the array-wide worst case. A table entry of zero counts as unprogrammed; such blocks use a separate default latency register, which comes out of reset at a safe maximum.

Control is a three-state machine:
- `ST_IDLE`: ready is high.
- `ST_PULSE`: the enable is high and the counter runs.
- `ST_DONE`: a one-cycle completion pulse.

The transitions are:
- ACCEPT, from `ST_IDLE` to `ST_PULSE`, when a request is valid.
- HOLD, from `ST_PULSE` to `ST_PULSE`, while the counter is above 1.
- EXPIRE, from `ST_PULSE` to `ST_DONE`, when the counter is 1.
- RELEASE, from `ST_DONE` to `ST_IDLE`, unconditionally.

Top module: `loc_reset_timer`

## Requirements
- R1: After reset, `req_ready` is 1, `rst_en` and `rst_done` are 0, all 16 table entries read as 0 (unprogrammed), and the default latency equals parameter `DFLT_RST` (24 by default).
- R2: A block ID b below 32 selects entry floor(b/2); a block ID b of 32 or more selects entry floor((63-b)/2). So blocks 0, 1, 62 and 63 share entry 0, and blocks 30 to 33 share entry 15.
- R3: When `req_valid` and `req_ready` are both high at a clock edge, `rst_en` rises after that edge and stays high for exactly L cycles, where L is the looked-up latency.
- R4: A block whose entry holds 0 uses the current default latency value as its L.
- R5: When `req_pair` is 1, L is the larger of the latencies for `req_blk_a` and `req_blk_b`. When `req_pair` is 0, `req_blk_b` is ignored.
- R6: `req_ready` is low from the acceptance edge until one cycle after `rst_en` falls. `rst_done` is high for exactly the one cycle right after `rst_en` falls.
- R7: A request held valid while the timer is busy is not accepted until `req_ready` returns. It does not change the pulse in progress.
- R8: A table write during a pulse does not change that pulse's length; the new value applies from the next accepted request. A table write on the acceptance edge itself does not affect that request, whose lookup uses the earlier value.
- R9: A write of 0 to the default latency register is ignored. A nonzero write applies from the next accepted request.
- R10: `tbl_addr` selects the table entry directly (entries 0 to 15). `tbl_data` is stored into that entry on a clock edge where `tbl_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | RESET request present |
| req_ready | output | 1 | Timer can accept a request |
| req_blk_a | input | 6 | First target block ID |
| req_blk_b | input | 6 | Second target block ID |
| req_pair | input | 1 | 1: `req_blk_b` is also reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_data | input | 16 | Latency in cycles (0 = unprogrammed) |
| dflt_we | input | 1 | Default latency write strobe |
| dflt_data | input | 16 | New default latency (0 ignored) |
| rst_en | output | 1 | RESET drive enable |
| rst_done | output | 1 | One-cycle completion pulse |

## Verification
The bench probes both ends and the centre of the mirror fold (blocks 0, 1, 62, 63, 30 to 33, and an off-centre mirrored pair). A fold that is off by one would time those blocks from a neighbouring entry, and the pulse lengths would come out wrong. It also sends paired requests with the larger latency on either side and with the pair flag cleared. A design that always uses one ID, or always reads the second ID, produces a pulse of the wrong length. It zeroes an entry and writes zero to the default register, which catches a design that drives a zero-length or stuck pulse. It rewrites the table mid-pulse and on the acceptance edge, which catches a design that re-reads the table while counting. A request is held waiting while the timer is busy, and the bench checks the ready/done spacing, which catches early acceptance or a done pulse that is late or too long.

// File: rtl/lrt_pkg.sv
`timescale 1ns/1ps
package lrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DONE  = 2'd2
    } pulse_state_e;
endpackage

// File: rtl/lrt_blk_map.sv
`timescale 1ns/1ps
// Folds a block ID onto its latency-table entry. Blocks at equal distance
// from the two array ends share one entry; pairs of neighbours share too.
module lrt_blk_map #(
    parameter int ID_W  = 6,
    localparam int IDX_W = ID_W - 2
) (
    input  logic [ID_W-1:0]  blk_id,
    output logic [IDX_W-1:0] ent_idx
);
    logic [ID_W-1:0] folded;

    always_comb begin
        // Upper half mirrors: (2^ID_W - 1) - id equals the bitwise inverse.
        folded  = blk_id[ID_W-1] ? ~blk_id : blk_id;
        ent_idx = IDX_W'(folded >> 1);
    end

    always_comb begin
        assert_fold_range_R2: assert (folded < (1 << (ID_W - 1)))
            else $error("fold produced upper-half value");
    end
endmodule

// File: rtl/lrt_lat_table.sv
`timescale 1ns/1ps
// Latency storage: one register per position group, plus the default
// register used by unprogrammed (zero) entries. NRD lookup ports.
module lrt_lat_table #(
    parameter int          N_ENT    = 16,
    parameter int          LAT_W    = 16,
    parameter int          NRD      = 2,
    parameter logic [15:0] DFLT_RST = 16'd24,
    localparam int         IDX_W    = $clog2(N_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbl_we,
    input  logic [IDX_W-1:0]           tbl_addr,
    input  logic [LAT_W-1:0]           tbl_data,
    input  logic                       dflt_we,
    input  logic [LAT_W-1:0]           dflt_data,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][LAT_W-1:0]  rd_lat
);
    logic [LAT_W-1:0] ent_q [N_ENT];
    logic [LAT_W-1:0] dflt_q;

    genvar gi;
    generate
        for (gi = 0; gi < N_ENT; gi++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q[gi] <= '0;
                end else if (tbl_we && (tbl_addr == IDX_W'(gi))) begin
                    ent_q[gi] <= tbl_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_q <= LAT_W'(DFLT_RST);
        end else if (dflt_we && (dflt_data != '0)) begin
            dflt_q <= dflt_data;
        end
    end

    generate
        for (gi = 0; gi < NRD; gi++) begin : g_rd
            always_comb begin
                rd_lat[gi] = (ent_q[rd_idx[gi]] == '0) ? dflt_q : ent_q[rd_idx[gi]];
            end
        end
    endgenerate

    assert_dflt_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_q != '0);

    assert_tbl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> ent_q[$past(tbl_addr)] == $past(tbl_data));
endmodule

// File: rtl/lrt_pulse_fsm.sv
`timescale 1ns/1ps
// Three-state pulse sequencer: IDLE (ready) -> PULSE (enable, counting)
// -> DONE (one-cycle completion) -> IDLE.
module lrt_pulse_fsm
    import lrt_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             use_b,
    input  logic [LAT_W-1:0] lat_a,
    input  logic [LAT_W-1:0] lat_b,
    output logic             req_ready,
    output logic             rst_en,
    output logic             rst_done
);
    pulse_state_e     state_q, state_nx;
    logic [LAT_W-1:0] cnt_q, cnt_nx;
    logic [LAT_W-1:0] load_lat;

    always_comb begin
        load_lat = (use_b && (lat_b > lat_a)) ? lat_b : lat_a;
    end

    // next-state and counter
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin            // ACCEPT
                    state_nx = ST_PULSE;
                    cnt_nx   = load_lat;
                end
            end
            ST_PULSE: begin
                cnt_nx = cnt_q - 1'b1;
                if (cnt_q == LAT_W'(1)) begin   // EXPIRE
                    state_nx = ST_DONE;
                end                             // else HOLD
            end
            ST_DONE: begin                      // RELEASE
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rst_en    = 1'b0;
        rst_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_PULSE: rst_en    = 1'b1;
            ST_DONE:  rst_done  = 1'b1;
            default:  ;
        endcase
    end

    assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> load_lat != '0);

    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rst_en && !req_ready));

    assert_cnt_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> cnt_q != '0);

    assert_en_excl_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_en, req_ready, rst_done}) == 1);

    assert_done_after_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_en) |-> rst_done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (!rst_done && req_ready));

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_en && cnt_q != LAT_W'(1)) |=> rst_en);
endmodule

// File: rtl/loc_reset_timer.sv
`timescale 1ns/1ps
// Top: maps both request block IDs to table entries, looks up their
// latencies and hands them to the pulse sequencer.
module loc_reset_timer #(
    parameter int          ID_W     = 6,
    parameter int          LAT_W    = 16,
    parameter logic [15:0] DFLT_RST = 16'd24,
    localparam int         IDX_W    = ID_W - 2,
    localparam int         N_ENT    = 1 << IDX_W,
    localparam int         NRD      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ID_W-1:0]  req_blk_a,
    input  logic [ID_W-1:0]  req_blk_b,
    input  logic             req_pair,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_addr,
    input  logic [LAT_W-1:0] tbl_data,
    input  logic             dflt_we,
    input  logic [LAT_W-1:0] dflt_data,
    output logic             rst_en,
    output logic             rst_done
);
    logic [NRD-1:0][ID_W-1:0]  blk_ids;
    logic [NRD-1:0][IDX_W-1:0] ent_idx;
    logic [NRD-1:0][LAT_W-1:0] ent_lat;

    assign blk_ids[0] = req_blk_a;
    assign blk_ids[1] = req_blk_b;

    genvar gi;
    generate
        for (gi = 0; gi < NRD; gi++) begin : g_map
            lrt_blk_map #(.ID_W(ID_W)) u_map (
                .blk_id  (blk_ids[gi]),
                .ent_idx (ent_idx[gi])
            );
        end
    endgenerate

    lrt_lat_table #(
        .N_ENT    (N_ENT),
        .LAT_W    (LAT_W),
        .NRD      (NRD),
        .DFLT_RST (DFLT_RST)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .dflt_we   (dflt_we),
        .dflt_data (dflt_data),
        .rd_idx    (ent_idx),
        .rd_lat    (ent_lat)
    );

    lrt_pulse_fsm #(.LAT_W(LAT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .use_b     (req_pair),
        .lat_a     (ent_lat[0]),
        .lat_b     (ent_lat[1]),
        .req_ready (req_ready),
        .rst_en    (rst_en),
        .rst_done  (rst_done)
    );
endmodule

// File: tb/loc_reset_timer_tb_top.sv
`timescale 1ns/1ps
module loc_reset_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_blk_a = '0;
    logic [5:0]  req_blk_b = '0;
    logic        req_pair = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic        dflt_we = 1'b0;
    logic [15:0] dflt_data = '0;
    logic        rst_en;
    logic        rst_done;

    always #2.5 clk = ~clk;

    loc_reset_timer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_blk_a(req_blk_a), .req_blk_b(req_blk_b), .req_pair(req_pair),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .dflt_we(dflt_we), .dflt_data(dflt_data),
        .rst_en(rst_en), .rst_done(rst_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench-side model of the table
    int mtbl [16];
    int mdflt = 24;

    int    exp_q [$];
    string tag_q [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_lat(input int b);
        int e;
        int v;
        if (b < 32) e = b / 2;
        else        e = (63 - b) / 2;
        v = mtbl[e];
        return (v == 0) ? mdflt : v;
    endfunction

    // monitor / scoreboard
    int run = 0;
    bit prev_en = 1'b0;
    bit after_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (after_done) begin
                chk(req_ready == 1'b1, "R6", "ready one cycle after done", int'(req_ready), 1);
                after_done = 1'b0;
            end
            if (prev_en && !rst_en)
                chk(rst_done == 1'b1, "R6", "done right after enable fall", int'(rst_done), 1);
            if (rst_en) run++;
            if (rst_done) begin
                chk(!rst_en && !req_ready, "R6", "done with enable and ready low",
                    int'({rst_en, req_ready}), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "pulse with no expected item", run, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(run == e, t, "pulse length", run, e);
                end
                run = 0;
                after_done = 1'b1;
            end
            prev_en = rst_en;
        end
    end

    task automatic tbl_write(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_data = 16'(d);
        @(posedge clk); #0.5;
        tbl_we = 1'b0;
        mtbl[a] = d;
    endtask

    task automatic dflt_write(input int d);
        @(negedge clk);
        dflt_we = 1'b1; dflt_data = 16'(d);
        @(posedge clk); #0.5;
        dflt_we = 1'b0;
        if (d != 0) mdflt = d;
    endtask

    // drive a request and return once it is accepted
    task automatic issue(input int a, input int b, input bit pair, input string tag);
        int e;
        @(negedge clk);
        req_valid = 1'b1; req_blk_a = 6'(a); req_blk_b = 6'(b); req_pair = pair;
        while (!req_ready) @(negedge clk);
        e = exp_lat(a);
        if (pair && exp_lat(b) > e) e = exp_lat(b);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #0.5;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && !after_done)) @(negedge clk);
    endtask

    task automatic req(input int a, input int b, input bit pair, input string tag);
        issue(a, b, pair, tag);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mtbl[i] = 0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rst_en == 1'b0, "R1", "enable after reset", int'(rst_en), 0);
        chk(rst_done == 1'b0, "R1", "done after reset", int'(rst_done), 0);

        // R1/R4: unprogrammed table uses reset default 24
        req(5, 0, 1'b0, "R1 default after reset");
        req(40, 0, 1'b0, "R4 unprogrammed entry");

        // R10: program every entry, value 3 + 2*i
        for (int i = 0; i < 16; i++) tbl_write(i, 3 + 2 * i);

        // R2: fold ends, centre, mirrored pair
        req(0, 0, 1'b0, "R2 block 0");
        req(1, 0, 1'b0, "R2 block 1");
        req(62, 0, 1'b0, "R2 block 62");
        req(63, 0, 1'b0, "R2 block 63");
        req(30, 0, 1'b0, "R2 block 30");
        req(31, 0, 1'b0, "R2 block 31");
        req(32, 0, 1'b0, "R2 block 32");
        req(33, 0, 1'b0, "R2 block 33");
        req(17, 0, 1'b0, "R2 block 17");
        req(46, 0, 1'b0, "R3 block 46");

        // R5: pairs
        req(0, 33, 1'b1, "R5 pair larger second");
        req(31, 2, 1'b1, "R5 pair larger first");
        req(0, 31, 1'b0, "R5 second ignored");

        // R4: zero entry falls back to default
        tbl_write(4, 0);
        req(9, 0, 1'b0, "R4 zeroed entry");
        req(9, 0, 1'b1, "R4 pair with default");

        // R7: request held while busy
        issue(2, 0, 1'b0, "R7 first pulse");
        issue(50, 0, 1'b0, "R7 held request");
        wait_idle();

        // R8: write during pulse
        issue(20, 0, 1'b0, "R8 pulse before rewrite");
        repeat (3) @(negedge clk);
        chk(rst_en == 1'b1, "R8", "enable high mid pulse", int'(rst_en), 1);
        tbl_write(10, 7);
        wait_idle();
        req(20, 0, 1'b0, "R8 rewritten value");

        // R8: write on acceptance edge uses earlier value
        @(negedge clk);
        req_valid = 1'b1; req_blk_a = 6'd21; req_pair = 1'b0;
        tbl_we = 1'b1; tbl_addr = 4'd10; tbl_data = 16'd15;
        exp_q.push_back(7);
        tag_q.push_back("R8 write on accept edge");
        @(posedge clk); #0.5;
        req_valid = 1'b0; tbl_we = 1'b0;
        mtbl[10] = 15;
        wait_idle();
        req(21, 0, 1'b0, "R8 value after accept-edge write");

        // R9: zero default write ignored, nonzero applied
        dflt_write(0);
        req(9, 0, 1'b0, "R9 zero default ignored");
        dflt_write(12);
        req(54, 0, 1'b0, "R9 new default");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all pulses observed", exp_q.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule